// File: doc/BRIEF.md
# GPIO Port with Interrupt Detection

This block is one general-purpose I/O port of up to eight pins, controlled through a small synchronous register bus. Each pin has its own window of registers. Through that window software switches the pin on, picks input or output, sets the level to drive, and can release the driver. It can also read the pin's settled input level, set a debounce length and configure how the pin raises an interrupt.

Every pad input goes through a two-flop synchronizer and an optional debounce filter. The filtered level feeds a per-pin trigger detector. The detector can watch for an active level, one chosen edge, or both edges. A detected event sets a sticky pending bit. Software clears that bit by writing to the pin's clear register. The pending bits of all pins also appear together in one port status word. A single interrupt line is raised whenever some pin that has its interrupt enable set holds a pending bit.

The bus has no handshake and never stalls. A write is taken on the clock edge where the write enable is high. Read data is registered: it shows the register addressed in cycle t during cycle t+1. The bus carries no streamed data, so the block has no valid/ready interface and no back-pressure.

Top module: `gpio_irq_port`

## Requirements
- R1: Pin n owns the byte addresses n*0x20 to n*0x20+0x1F. The config word sits at offset 0x00 of that window. Its fields are: bit 0 enable, bit 1 output direction, bits 3:2 trigger kind, bit 4 polarity, bit 6 interrupt enable. It reads back exactly what was written in those bits, and the other bits read 0. A write to one pin's window leaves every other pin unchanged.
- R2: Offset 0x04 holds an 8-bit debounce length in bits 7:0. It reads back with bits 31:8 equal to 0.
- R3: Offset 0x08 is read-only. Its bit 0 is the settled pad level. With a debounce length of 0, a change passes the two-flop synchronizer plus one register. With length k > 0, a new level is taken only after the synchronized input has differed from the settled level for k consecutive clocks. Shorter pulses are dropped.
- R4: Offset 0x0C bit 0 is a float control and offset 0x10 bit 0 is the drive level. Both read back in bit 0. pad_oe is high only when enable, output direction and not-float all hold. pad_out equals the drive level while pad_oe is high and is 0 otherwise.
- R5: Trigger kind 0 never sets the pending bit.
- R6: Trigger kind 1 (level) sets pending while the settled level equals the polarity bit (1 means active high, 0 means active low).
- R7: Trigger kind 2 (one edge) sets pending on a rising edge when polarity is 1, and on a falling edge when polarity is 0. The opposite edge is ignored.
- R8: Trigger kind 3 sets pending on both edges, whatever the polarity.
- R9: Writing a word with bit 0 set to offset 0x14 clears that pin's pending bit. With level trigger, the bit is set again at once while the active level persists. A pending bit falls only after such a write.
- R10: Events are latched only while the pin's enable bit is 1.
- R11: Address 0x104 reads the pending bits, with bit n belonging to pin n. irq is the OR of the pending bits whose interrupt enable is set. A pending bit with interrupt enable 0 shows in the status word but does not raise irq.
- R12: Unmapped addresses read 0. This includes unused offsets inside a window and the status slots at 0x100 and 0x108. The read data always follows the address by exactly one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 12 | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle it is high |
| bus_rdata | output | 32 | Registered read data for the previous cycle's address |
| pad_in | input | 8 | Raw pad input levels, asynchronous |
| pad_out | output | 8 | Level to drive on each pad |
| pad_oe | output | 8 | Driver enable for each pad |
| irq | output | 1 | Combined port interrupt |

## Verification
The bound checker watches rules that must hold in every cycle. A pad may drive only while its pin is enabled. pad_out stays low while its driver is released. irq may be high only when some enabled pending bit backs it. A pending bit may rise only when its pin was enabled, and may fall only after a clear write to that pin. The bench scenarios cover what depends on history and input sequences: debounce rejection of short pulses, the edge-versus-level choice for each polarity, a level pending that returns after a clear, and readback of every register field under randomized configurations.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  typedef enum logic [1:0] {
    TRIG_OFF        = 2'd0,
    TRIG_LEVEL      = 2'd1,
    TRIG_ONE_EDGE   = 2'd2,
    TRIG_BOTH_EDGES = 2'd3
  } trig_kind_e;

  typedef struct packed {
    logic       irq_en;
    logic       polarity;
    trig_kind_e kind;
    logic       is_out;
    logic       enable;
  } pin_cfg_t;

  localparam int          WIN_SHIFT  = 5;
  localparam logic [4:0]  OFS_CFG    = 5'h00;
  localparam logic [4:0]  OFS_DBNC   = 5'h04;
  localparam logic [4:0]  OFS_LEVEL  = 5'h08;
  localparam logic [4:0]  OFS_FLOAT  = 5'h0C;
  localparam logic [4:0]  OFS_DRIVE  = 5'h10;
  localparam logic [4:0]  OFS_CLEAR  = 5'h14;
  localparam int          STAT_BASE  = 'h100;
  localparam int          STAT_SLOT  = 1;
  localparam int          CFG_BITS   = 7;

  function automatic logic [CFG_BITS-1:0] cfg_to_word(input pin_cfg_t c);
    logic [CFG_BITS-1:0] w;
    w    = '0;
    w[0] = c.enable;
    w[1] = c.is_out;
    w[3:2] = c.kind;
    w[4] = c.polarity;
    w[6] = c.irq_en;
    return w;
  endfunction

  function automatic pin_cfg_t word_to_cfg(input logic [CFG_BITS-1:0] w);
    pin_cfg_t c;
    c.enable   = w[0];
    c.is_out   = w[1];
    c.kind     = trig_kind_e'(w[3:2]);
    c.polarity = w[4];
    c.irq_en   = w[6];
    return c;
  endfunction

endpackage

// File: rtl/gpio_debounce.sv
module gpio_debounce #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             raw,
  input  logic [CNT_W-1:0] thr,
  output logic             level_o
);
  logic             sync_a, sync_b, settled;
  logic [CNT_W-1:0] run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_a  <= 1'b0;
      sync_b  <= 1'b0;
      settled <= 1'b0;
      run_len <= '0;
    end else begin
      sync_a <= raw;
      sync_b <= sync_a;
      if (thr == '0) begin
        settled <= sync_b;
        run_len <= '0;
      end else if (sync_b == settled) begin
        run_len <= '0;
      end else if (run_len == thr - CNT_W'(1)) begin
        settled <= sync_b;
        run_len <= '0;
      end else begin
        run_len <= run_len + CNT_W'(1);
      end
    end
  end

  assign level_o = settled;
endmodule

// File: rtl/gpio_trigger.sv
module gpio_trigger
  import gpio_irq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     level,
  input  pin_cfg_t cfg,
  input  logic     clr,
  output logic     pending_o
);
  logic prev_level, pending, hit, rise, fall;

  assign rise = level & ~prev_level;
  assign fall = ~level & prev_level;

  always_comb begin
    unique case (cfg.kind)
      TRIG_OFF:        hit = 1'b0;
      TRIG_LEVEL:      hit = (level == cfg.polarity);
      TRIG_ONE_EDGE:   hit = cfg.polarity ? rise : fall;
      TRIG_BOTH_EDGES: hit = rise | fall;
      default:         hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_level <= 1'b0;
      pending    <= 1'b0;
    end else begin
      prev_level <= level;
      pending    <= (pending & ~clr) | (cfg.enable & hit);
    end
  end

  assign pending_o = pending;
endmodule

// File: rtl/gpio_pin_regs.sv
module gpio_pin_regs
  import gpio_irq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [4:0]       ofs,
  input  logic [CNT_W-1:0] wdata,
  output pin_cfg_t         cfg,
  output logic [CNT_W-1:0] thr,
  output logic             float_q,
  output logic             drive_q,
  output logic             clr_pulse
);
  localparam int LOW_W = (CNT_W > CFG_BITS) ? CNT_W : CFG_BITS;
  logic [LOW_W-1:0] wd;
  assign wd = LOW_W'(wdata);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg     <= '0;
      thr     <= '0;
      float_q <= 1'b0;
      drive_q <= 1'b0;
    end else if (wr_en) begin
      unique case (ofs)
        OFS_CFG:   cfg     <= word_to_cfg(wd[CFG_BITS-1:0]);
        OFS_DBNC:  thr     <= wd[CNT_W-1:0];
        OFS_FLOAT: float_q <= wd[0];
        OFS_DRIVE: drive_q <= wd[0];
        default:   ;
      endcase
    end
  end

  assign clr_pulse = wr_en && (ofs == OFS_CLEAR) && wd[0];
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 32,
  parameter int CNT_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NUM_PINS-1:0] pad_in,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pad_oe,
  output logic              irq
);
  localparam int IDX_W = ADDR_W - WIN_SHIFT;
  localparam int SEL_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;
  localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(STAT_BASE + 4 * STAT_SLOT);

  logic [IDX_W-1:0]  win_idx;
  logic [4:0]        ofs;
  logic              pin_ok;
  logic [SEL_W-1:0]  sel;
  logic [DATA_W-1:0] rd_next;
  logic              unused_wdata;

  pin_cfg_t          cfg_v   [NUM_PINS];
  logic [CNT_W-1:0]  thr_v   [NUM_PINS];
  logic [NUM_PINS-1:0] en_vec, ie_vec, pend_vec, clr_vec;
  logic [NUM_PINS-1:0] level_vec, float_vec, drive_vec;

  assign win_idx = bus_addr[ADDR_W-1:WIN_SHIFT];
  assign ofs     = bus_addr[4:0];
  assign pin_ok  = (32'(bus_addr) < STAT_BASE) && (32'(win_idx) < NUM_PINS);
  assign sel     = SEL_W'(win_idx);
  assign unused_wdata = ^bus_wdata;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic wr_here;
    assign wr_here = bus_we && pin_ok && (32'(win_idx) == i);

    gpio_pin_regs #(.CNT_W(CNT_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_here),
      .ofs      (ofs),
      .wdata    (bus_wdata[CNT_W-1:0]),
      .cfg      (cfg_v[i]),
      .thr      (thr_v[i]),
      .float_q  (float_vec[i]),
      .drive_q  (drive_vec[i]),
      .clr_pulse(clr_vec[i])
    );

    gpio_debounce #(.CNT_W(CNT_W)) u_dbnc (
      .clk    (clk),
      .rst_n  (rst_n),
      .raw    (pad_in[i]),
      .thr    (thr_v[i]),
      .level_o(level_vec[i])
    );

    gpio_trigger u_trig (
      .clk      (clk),
      .rst_n    (rst_n),
      .level    (level_vec[i]),
      .cfg      (cfg_v[i]),
      .clr      (clr_vec[i]),
      .pending_o(pend_vec[i])
    );

    assign en_vec[i]  = cfg_v[i].enable;
    assign ie_vec[i]  = cfg_v[i].irq_en;
    assign pad_oe[i]  = cfg_v[i].enable & cfg_v[i].is_out & ~float_vec[i];
    assign pad_out[i] = pad_oe[i] & drive_vec[i];
  end

  assign irq = |(pend_vec & ie_vec);

  always_comb begin
    rd_next = '0;
    if (pin_ok) begin
      unique case (ofs)
        OFS_CFG:   rd_next = DATA_W'(cfg_to_word(cfg_v[sel]));
        OFS_DBNC:  rd_next = DATA_W'(thr_v[sel]);
        OFS_LEVEL: rd_next = DATA_W'(level_vec[sel]);
        OFS_FLOAT: rd_next = DATA_W'(float_vec[sel]);
        OFS_DRIVE: rd_next = DATA_W'(drive_vec[sel]);
        default:   rd_next = '0;
      endcase
    end else if (bus_addr == STAT_ADDR) begin
      rd_next = DATA_W'(pend_vec);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_rdata <= '0;
    else        bus_rdata <= rd_next;
  end
endmodule

// File: rtl/gpio_irq_port_chk.sv
module gpio_irq_port_chk #(
  parameter int NUM_PINS = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NUM_PINS-1:0] en_vec,
  input logic [NUM_PINS-1:0] ie_vec,
  input logic [NUM_PINS-1:0] pend_vec,
  input logic [NUM_PINS-1:0] clr_vec,
  input logic [NUM_PINS-1:0] pad_oe,
  input logic [NUM_PINS-1:0] pad_out,
  input logic                irq
);
  p_drive_needs_enable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & ~en_vec) == '0);

  p_quiet_when_released_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_out & ~pad_oe) == '0);

  p_irq_has_source_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((pend_vec & ie_vec) != '0));

  p_latch_needs_enable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_vec & ~$past(pend_vec)) & ~$past(en_vec)) == '0);

  p_clear_only_by_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(pend_vec) & ~pend_vec) & ~$past(clr_vec)) == '0);
endmodule

bind gpio_irq_port gpio_irq_port_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .en_vec  (en_vec),
  .ie_vec  (ie_vec),
  .pend_vec(pend_vec),
  .clr_vec (clr_vec),
  .pad_oe  (pad_oe),
  .pad_out (pad_out),
  .irq     (irq)
);

// File: tb/gpio_irq_port_bench.sv
module gpio_irq_port_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_rdata;
  logic [7:0]  pad_in = '0;
  logic [7:0]  pad_out, pad_oe;
  logic        irq;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  gpio_irq_port u_gpio_irq_port (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [11:0] pa(input int pin, input int ofs);
    return 12'(pin * 32 + ofs);
  endfunction

  function automatic logic [31:0] cfg_rb(input logic [31:0] w);
    return w & 32'h0000_005F;
  endfunction

  function automatic logic exp_oe(input logic [31:0] c, input logic flt);
    return c[0] & c[1] & ~flt;
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic stat_bit(input string req, input int pin, input logic exp);
    logic [31:0] s;
    rd(12'h104, s);
    check(req, 32'(s[pin]), 32'(exp));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog got=hung exp=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, c, t;
    logic f, v;
    int p;
    void'($urandom(32'h5eed_0042));
    idle(4);
    rst_n = 1'b1;
    idle(1);

    rd(pa(0, 0), d);
    check("R1 reset config", d, 32'h0);
    check("R4 reset pad_oe", 32'(pad_oe), 32'h0);
    check("R11 reset irq", 32'(irq), 32'h0);

    // Randomized register fields, R1 R2 R4
    for (int k = 0; k < 24; k++) begin
      p = int'($urandom % 8);
      c = $urandom; t = $urandom;
      f = 1'($urandom); v = 1'($urandom);
      wr(pa(p, 'h00), c);
      wr(pa(p, 'h04), t);
      wr(pa(p, 'h0C), 32'(f));
      wr(pa(p, 'h10), 32'(v));
      rd(pa(p, 'h00), d); check("R1 config readback", d, cfg_rb(c));
      rd(pa(p, 'h04), d); check("R2 debounce readback", d, t & 32'hFF);
      rd(pa(p, 'h0C), d); check("R4 float readback", d, 32'(f));
      rd(pa(p, 'h10), d); check("R4 drive readback", d, 32'(v));
      check("R4 pad_oe", 32'(pad_oe[p]), 32'(exp_oe(c, f)));
      check("R4 pad_out", 32'(pad_out[p]), 32'(exp_oe(c, f) & v));
    end
    for (int q = 0; q < 8; q++) begin
      wr(pa(q, 'h00), 0); wr(pa(q, 'h04), 0);
      wr(pa(q, 'h0C), 0); wr(pa(q, 'h10), 0);
      wr(pa(q, 'h14), 1);
    end
    rd(12'h104, d);
    check("R9 all pending cleared", d, 32'h0);

    // R1 window isolation
    wr(pa(7, 0), 32'h40);
    rd(pa(7, 0), d); check("R1 pin7 config", d, 32'h40);
    rd(pa(6, 0), d); check("R1 pin6 untouched", d, 32'h0);
    wr(pa(7, 0), 0);

    // R3 no debounce
    pad_in[6] = 1'b1; idle(4);
    rd(pa(6, 'h08), d); check("R3 level high", d, 32'h1);
    pad_in[6] = 1'b0; idle(4);
    rd(pa(6, 'h08), d); check("R3 level low", d, 32'h0);

    // R3 debounce length 5 on pin 2
    wr(pa(2, 'h04), 5);
    pad_in[2] = 1'b1; idle(3); pad_in[2] = 1'b0; idle(6);
    rd(pa(2, 'h08), d); check("R3 glitch rejected", d, 32'h0);
    pad_in[2] = 1'b1; idle(5);
    rd(pa(2, 'h08), d); check("R3 not yet settled", d, 32'h0);
    idle(4);
    rd(pa(2, 'h08), d); check("R3 settled after run", d, 32'h1);

    // R5 trigger off
    wr(pa(5, 0), 32'h01);
    pad_in[5] = 1'b1; idle(6); pad_in[5] = 1'b0; idle(6);
    stat_bit("R5 no latch", 5, 1'b0);

    // R7 single edge on pin 0
    wr(pa(0, 0), 32'h19);
    pad_in[0] = 1'b1; idle(6);
    stat_bit("R7 rising latched", 0, 1'b1);
    wr(pa(0, 'h14), 1);
    stat_bit("R9 edge cleared", 0, 1'b0);
    pad_in[0] = 1'b0; idle(6);
    stat_bit("R7 falling ignored", 0, 1'b0);
    wr(pa(0, 0), 32'h09);
    pad_in[0] = 1'b1; idle(6);
    stat_bit("R7 rising ignored pol0", 0, 1'b0);
    pad_in[0] = 1'b0; idle(6);
    stat_bit("R7 falling latched pol0", 0, 1'b1);
    wr(pa(0, 'h14), 1);

    // R8 both edges on pin 1 (polarity 0)
    wr(pa(1, 0), 32'h0D);
    pad_in[1] = 1'b1; idle(6);
    stat_bit("R8 rise", 1, 1'b1);
    wr(pa(1, 'h14), 1);
    pad_in[1] = 1'b0; idle(6);
    stat_bit("R8 fall", 1, 1'b1);
    wr(pa(1, 'h14), 1);
    stat_bit("R8 cleared", 1, 1'b0);

    // R6 / R9 level on pin 3
    wr(pa(3, 0), 32'h05); idle(2);
    stat_bit("R6 active low", 3, 1'b1);
    wr(pa(3, 'h14), 1);
    stat_bit("R9 level re-pends", 3, 1'b1);
    pad_in[3] = 1'b1; idle(6);
    wr(pa(3, 'h14), 1);
    stat_bit("R9 level released", 3, 1'b0);
    wr(pa(3, 0), 32'h15); idle(2);
    stat_bit("R6 active high", 3, 1'b1);
    pad_in[3] = 1'b0; idle(6);
    wr(pa(3, 'h14), 1);
    stat_bit("R6 inactive clears", 3, 1'b0);

    // R10 disabled pin 4
    wr(pa(4, 0), 32'h0C);
    pad_in[4] = 1'b1; idle(6); pad_in[4] = 1'b0; idle(6);
    stat_bit("R10 disabled no latch", 4, 1'b0);
    wr(pa(4, 0), 32'h0D);
    pad_in[4] = 1'b1; idle(6);
    stat_bit("R10 enabled latches", 4, 1'b1);
    wr(pa(4, 'h14), 1);

    // R11 interrupt gating on pin 0
    wr(pa(0, 0), 32'h19);
    pad_in[0] = 1'b1; idle(6);
    stat_bit("R11 pending shown", 0, 1'b1);
    check("R11 masked irq", 32'(irq), 32'h0);
    wr(pa(0, 0), 32'h59);
    check("R11 irq raised", 32'(irq), 32'h1);
    wr(pa(0, 'h14), 1);
    check("R11 irq dropped", 32'(irq), 32'h0);

    // R12 unmapped reads and latency
    rd(12'h018, d); check("R12 unused offset", d, 32'h0);
    rd(12'h100, d); check("R12 status slot 0", d, 32'h0);
    rd(12'h108, d); check("R12 status slot 2", d, 32'h0);
    wr(pa(6, 0), 32'h13);
    @(negedge clk); bus_addr = pa(6, 0);
    @(negedge clk); bus_addr = 12'h018;
    check("R12 one-cycle latency", bus_rdata, 32'h13);
    @(negedge clk);
    check("R12 follows address", bus_rdata, 32'h0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule